// File: doc/BRIEF.md
# Invalidate Completion Tag Coalescer

This block sits in a device-side address translation cache, between the link receive path and the cache flush logic. Invalidate requests arrive on a valid/ready stream, each carrying a 5-bit invalidate tag and the sender's 16-bit requester ID. The block passes each request to the flush logic on a second valid/ready stream and records the tag as outstanding. When that logic has finished a tag, it reports this with a one-cycle bit in a per-tag done mask. Finished tags then collect into a single pending bit per tag. The block emits them as one coalesced completion on an output valid/ready stream. Each completion carries a 32-bit tag vector, a completion count, the completion message code and a routing ID. The routing ID is latched once, from the first request accepted after reset.

Back-pressure rules: a request is taken only in a cycle where `req_valid`, `fwd_ready` and the not-full condition all hold. The request stream and the forward stream share that one handshake. The completion stream holds `cpl_vec` and `cpl_rid` stable while `cpl_valid` is high and `cpl_ready` is low. Tags that finish during such a stall wait for the next completion. The advertised queue depth and the constant message fields are plain outputs.

Top module: `inval_cpl_coalescer`

## Requirements
- R1: `qdepth` reports the number of requests that can be outstanding. A depth of 32 is encoded as 5'd0, so the default gives 0.
- R2: When all 32 tags are outstanding and not yet reported, `req_ready` and `fwd_valid` are 0. They return to 1 in the cycle after the completion that frees a tag is accepted.
- R3: A request is accepted exactly when `req_valid`, `fwd_ready` and not-full all hold. `fwd_valid` equals `req_valid` while not full, and `fwd_tag` equals `req_tag`.
- R4: `cpl_rid` carries the requester ID of the first request accepted after reset. Later requests with other IDs do not change it.
- R5: Done bits raised in the same cycle for several outstanding tags produce one completion with those bits set, where bit n of `cpl_vec` stands for tag n. For example, tags 0, 1, 3, 6 and 8 give 32'h0000_014B. A done bit raised at edge k appears on `cpl_valid` after edge k+1 when the output is idle.
- R6: While `cpl_valid` is 1 and `cpl_ready` is 0, `cpl_vec` and `cpl_rid` hold. Tags that finish during the stall appear in the next completion.
- R7: A done bit for a tag that is not outstanding, or that is already pending or in the waiting completion, has no effect. It never produces a completion.
- R8: `cpl_code` is 8'h02, the invalidate completion message code. `cpl_count` is 3'd1 for the default single traffic class, and eight completions would be encoded as 3'd0.
- R9: When a completion is accepted, its tags stop being outstanding and can be requested again.
- R10: Reset clears all outstanding, pending and waiting state. No completion is emitted for requests that were in flight, and the routing ID is captured again from the first request after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Invalidate request valid |
| req_ready | output | 1 | Invalidate request ready |
| req_tag | input | 5 | Invalidate tag of the request |
| req_rid | input | 16 | Requester ID of the request |
| fwd_valid | output | 1 | Request valid toward flush logic |
| fwd_ready | input | 1 | Flush logic can take a request |
| fwd_tag | output | 5 | Tag forwarded to flush logic |
| done_mask | input | 32 | One-cycle per-tag flush finished bits |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion accepted by packet builder |
| cpl_vec | output | 32 | Tag vector of the completion |
| cpl_count | output | 3 | Completion count field |
| cpl_rid | output | 16 | Routing ID for the completion |
| cpl_code | output | 8 | Completion message code |
| qdepth | output | 5 | Advertised invalidate queue depth |

## Verification
The hardest situation to reach is the full queue. All 32 tags must be outstanding at once, and the queue must then be drained through a coalesced completion so that a tag is freed again. The stimulus issues all 32 tags back to back and then offers one more request, which must be refused. It then finishes one tag and accepts its completion, so that `req_ready` comes back one cycle later. Stalling `cpl_ready` while new done bits arrive covers the hold-and-merge path, and a reset with work in flight covers the dropped state.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam logic [7:0] MSG_INV_REQ = 8'h01;
  localparam logic [7:0] MSG_INV_CPL = 8'h02;

  // depth field: full 2^width wraps to zero
  function automatic logic [4:0] depth_code(input int unsigned n);
    return (n >= 32) ? 5'd0 : n[4:0];
  endfunction

  // completion count field: eight wraps to zero
  function automatic logic [2:0] count_code(input int unsigned n);
    return (n >= 8) ? 3'd0 : n[2:0];
  endfunction
endpackage

// File: rtl/icc_tag_tracker.sv
module icc_tag_tracker #(
  parameter int unsigned NUM_TAGS = 32,
  localparam int unsigned TAG_W = $clog2(NUM_TAGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [TAG_W-1:0]    set_tag,
  input  logic [NUM_TAGS-1:0] clr_mask,
  output logic [NUM_TAGS-1:0] outst,
  output logic                full
);
  logic [NUM_TAGS-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    if (set_en) set_mask[set_tag] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= '0;
    else        outst <= (outst & ~clr_mask) | set_mask;
  end

  assign full = &outst;
endmodule

// File: rtl/icc_done_collector.sv
module icc_done_collector #(
  parameter int unsigned NUM_TAGS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAGS-1:0] done_mask,
  input  logic [NUM_TAGS-1:0] outst,
  input  logic                cpl_ready,
  output logic                cpl_valid,
  output logic [NUM_TAGS-1:0] cpl_vec
);
  logic [NUM_TAGS-1:0] pend;
  logic [NUM_TAGS-1:0] busy;
  logic [NUM_TAGS-1:0] eligible;
  logic                load;

  assign busy     = pend | (cpl_valid ? cpl_vec : '0);
  assign eligible = done_mask & outst & ~busy;
  assign load     = !cpl_valid || cpl_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      cpl_valid <= 1'b0;
      cpl_vec   <= '0;
    end else if (load) begin
      cpl_valid <= |pend;
      cpl_vec   <= pend;
      pend      <= eligible;
    end else begin
      pend      <= pend | eligible;
    end
  end
endmodule

// File: rtl/icc_rid_latch.sv
module icc_rid_latch #(
  parameter int unsigned RID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [RID_W-1:0] rid_in,
  output logic [RID_W-1:0] rid_q
);
  logic held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= 1'b0;
      rid_q <= '0;
    end else if (capture && !held) begin
      held  <= 1'b1;
      rid_q <= rid_in;
    end
  end
endmodule

// File: rtl/inval_cpl_coalescer.sv
module inval_cpl_coalescer #(
  parameter int unsigned NUM_TAGS = 32,
  parameter int unsigned RID_W    = 16,
  parameter int unsigned NUM_TC   = 1,
  localparam int unsigned TAG_W   = $clog2(NUM_TAGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [TAG_W-1:0]    req_tag,
  input  logic [RID_W-1:0]    req_rid,
  output logic                fwd_valid,
  input  logic                fwd_ready,
  output logic [TAG_W-1:0]    fwd_tag,
  input  logic [NUM_TAGS-1:0] done_mask,
  output logic                cpl_valid,
  input  logic                cpl_ready,
  output logic [NUM_TAGS-1:0] cpl_vec,
  output logic [2:0]          cpl_count,
  output logic [RID_W-1:0]    cpl_rid,
  output logic [7:0]          cpl_code,
  output logic [4:0]          qdepth
);
  import icc_pkg::*;

  logic [NUM_TAGS-1:0] outst;
  logic [NUM_TAGS-1:0] clr_mask;
  logic                full;
  logic                accept;

  assign req_ready = fwd_ready && !full;
  assign fwd_valid = req_valid && !full;
  assign fwd_tag   = req_tag;
  assign accept    = req_valid && req_ready;
  assign clr_mask  = (cpl_valid && cpl_ready) ? cpl_vec : '0;

  assign cpl_count = count_code(NUM_TC);
  assign cpl_code  = MSG_INV_CPL;
  assign qdepth    = depth_code(NUM_TAGS);

  icc_tag_tracker #(.NUM_TAGS(NUM_TAGS)) u_track (
    .clk(clk), .rst_n(rst_n), .set_en(accept), .set_tag(req_tag),
    .clr_mask(clr_mask), .outst(outst), .full(full)
  );

  icc_done_collector #(.NUM_TAGS(NUM_TAGS)) u_coll (
    .clk(clk), .rst_n(rst_n), .done_mask(done_mask), .outst(outst),
    .cpl_ready(cpl_ready), .cpl_valid(cpl_valid), .cpl_vec(cpl_vec)
  );

  icc_rid_latch #(.RID_W(RID_W)) u_rid (
    .clk(clk), .rst_n(rst_n), .capture(accept), .rid_in(req_rid),
    .rid_q(cpl_rid)
  );
endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int unsigned NUM_TAGS = 32,
  parameter int unsigned RID_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                fwd_valid,
  input logic                cpl_valid,
  input logic                cpl_ready,
  input logic [NUM_TAGS-1:0] cpl_vec,
  input logic [RID_W-1:0]    cpl_rid,
  input logic [NUM_TAGS-1:0] outst
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else if (req_valid && req_ready) seen <= 1'b1;
  end

  AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(outst) == NUM_TAGS) |-> (!req_ready && !fwd_valid)); // R2

  AST_CPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_vec) && $stable(cpl_rid))); // R6

  AST_CPL_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (cpl_vec != '0)); // R5

  AST_CPL_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> ((cpl_vec & ~outst) == '0)); // R7

  AST_RID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(seen)) |-> $stable(cpl_rid)); // R4

  AST_FREED_AFTER_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_ready) |=> ((outst & $past(cpl_vec)) == '0)
      || $past(req_valid && req_ready)); // R9
endmodule

bind inval_cpl_coalescer icc_checker #(.NUM_TAGS(NUM_TAGS), .RID_W(RID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .fwd_valid(fwd_valid), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
  .cpl_vec(cpl_vec), .cpl_rid(cpl_rid), .outst(outst)
);

// File: tb/test_inval_cpl_coalescer.sv
module test_inval_cpl_coalescer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [4:0]  req_tag;
  logic [15:0] req_rid;
  logic        fwd_valid, fwd_ready;
  logic [4:0]  fwd_tag;
  logic [31:0] done_mask;
  logic        cpl_valid, cpl_ready;
  logic [31:0] cpl_vec;
  logic [2:0]  cpl_count;
  logic [15:0] cpl_rid;
  logic [7:0]  cpl_code;
  logic [4:0]  qdepth;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  inval_cpl_coalescer i_inval_cpl_coalescer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tag(req_tag), .req_rid(req_rid), .fwd_valid(fwd_valid),
    .fwd_ready(fwd_ready), .fwd_tag(fwd_tag), .done_mask(done_mask),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_vec(cpl_vec),
    .cpl_count(cpl_count), .cpl_rid(cpl_rid), .cpl_code(cpl_code),
    .qdepth(qdepth)
  );

  // behavioural reference: sets of tags in each state
  bit          m_out[32];
  bit          m_pend[32];
  bit          m_slot[32];
  bit          m_slot_v;
  int          m_rid;
  bit          m_rid_ok;

  function automatic int m_count_out();
    int c = 0;
    for (int i = 0; i < 32; i++) c += m_out[i];
    return c;
  endfunction

  function automatic logic [31:0] m_slot_word();
    logic [31:0] w = '0;
    for (int i = 0; i < 32; i++) w[i] = m_slot[i];
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin m_out[i] = 0; m_pend[i] = 0; m_slot[i] = 0; end
      m_slot_v = 0; m_rid = 0; m_rid_ok = 0;
    end else begin
      bit take, fire, any;
      bit newd[32];
      take = req_valid && fwd_ready && (m_count_out() < 32);
      fire = m_slot_v && cpl_ready;
      for (int i = 0; i < 32; i++)
        newd[i] = done_mask[i] && m_out[i] && !m_pend[i] && !(m_slot_v && m_slot[i]);
      for (int i = 0; i < 32; i++) if (fire && m_slot[i]) m_out[i] = 0;
      if (take) begin
        m_out[req_tag] = 1;
        if (!m_rid_ok) begin m_rid = req_rid; m_rid_ok = 1; end
      end
      if (!m_slot_v || cpl_ready) begin
        any = 0;
        for (int i = 0; i < 32; i++) begin
          m_slot[i] = m_pend[i]; any |= m_pend[i]; m_pend[i] = newd[i];
        end
        m_slot_v = any;
      end else begin
        for (int i = 0; i < 32; i++) m_pend[i] = m_pend[i] | newd[i];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // inputs already set for this cycle: compare outputs against the model
  task automatic compare();
    logic exp_rdy;
    #1;
    exp_rdy = fwd_ready && (m_count_out() < 32);
    check(req_ready === exp_rdy, "R2 req_ready", {31'd0, req_ready}, {31'd0, exp_rdy});
    check(fwd_valid === (req_valid && m_count_out() < 32), "R3 fwd_valid",
          {31'd0, fwd_valid}, {31'd0, req_valid && m_count_out() < 32});
    check(cpl_valid === m_slot_v, "R5 cpl_valid", {31'd0, cpl_valid}, {31'd0, m_slot_v});
    if (m_slot_v) begin
      check(cpl_vec === m_slot_word(), "R5 cpl_vec", cpl_vec, m_slot_word());
      check(cpl_rid === m_rid[15:0], "R4 cpl_rid", {16'd0, cpl_rid}, {16'd0, m_rid[15:0]});
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic send(input int tag, input logic [15:0] rid);
    @(negedge clk);
    req_valid = 1; req_tag = tag[4:0]; req_rid = rid;
    compare();
    @(negedge clk);
    req_valid = 0;
    compare();
  endtask

  task automatic pulse_done(input logic [31:0] m);
    @(negedge clk);
    done_mask = m;
    compare();
    @(negedge clk);
    done_mask = '0;
    compare();
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_tag = 0; req_rid = 0;
    fwd_ready = 1; done_mask = '0; cpl_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    check(qdepth === 5'd0, "R1 qdepth", {27'd0, qdepth}, 32'd0);
    check(cpl_code === 8'h02, "R8 cpl_code", {24'd0, cpl_code}, 32'h2);
    check(cpl_count === 3'd1, "R8 cpl_count", {29'd0, cpl_count}, 32'd1);
    check(cpl_valid === 1'b0, "R10 reset cpl_valid", {31'd0, cpl_valid}, 32'd0);

    // R4 capture on first request, later IDs ignored
    send(0, 16'hABCD); send(1, 16'h1234); send(3, 16'h1234);
    send(6, 16'h1234); send(8, 16'h1234); send(9, 16'h1234);

    // R3 forward stall blocks acceptance
    @(negedge clk);
    fwd_ready = 0; req_valid = 1; req_tag = 5'd12;
    compare();
    check(req_ready === 1'b0 && fwd_valid === 1'b1 && fwd_tag === 5'd12, "R3 fwd stall",
          {26'd0, req_ready, fwd_valid, fwd_tag[3:0]}, {26'd0, 2'b01, 4'd12});
    @(negedge clk);
    req_valid = 0; fwd_ready = 1;
    compare();

    // R5 coalesced vector
    pulse_done(32'h0000_014B);
    step();
    check(cpl_valid === 1'b1 && cpl_vec === 32'h0000_014B, "R5 coalesced vector", cpl_vec, 32'h14B);
    check(cpl_rid === 16'hABCD, "R4 captured rid", {16'd0, cpl_rid}, 32'hABCD);

    // R6 stalled output holds while tag 9 finishes
    pulse_done(32'h0000_0200);
    step(); step();
    check(cpl_vec === 32'h0000_014B, "R6 hold under stall", cpl_vec, 32'h14B);
    // R7 duplicate done on a waiting tag and done on idle tag 20
    pulse_done(32'h0010_0001);
    @(negedge clk); cpl_ready = 1; compare();
    step();
    check(cpl_vec === 32'h0000_0200, "R6 merged later tag", cpl_vec, 32'h200);
    repeat (4) step();
    check(cpl_valid === 1'b0, "R7 ignored done", {31'd0, cpl_valid}, 32'd0);

    // R2 fill all 32 tags
    for (int t = 0; t < 32; t++) send(t, 16'h5555);
    @(negedge clk);
    req_valid = 1; req_tag = 5'd4;
    compare();
    check(req_ready === 1'b0 && fwd_valid === 1'b0, "R2 full backpressure",
          {30'd0, req_ready, fwd_valid}, 32'd0);
    @(negedge clk); req_valid = 0; compare();
    // R9 free tag 7 via completion
    pulse_done(32'h0000_0080);
    step();
    check(cpl_vec === 32'h0000_0080, "R9 single completion", cpl_vec, 32'h80);
    step();
    check(req_ready === 1'b1, "R9 tag freed", {31'd0, req_ready}, 32'd1);
    send(7, 16'h5555);

    // R10 reset with work in flight
    cpl_ready = 0;
    pulse_done(32'hFFFF_FFFF);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; compare();
    repeat (4) step();
    check(cpl_valid === 1'b0, "R10 no completion after reset", {31'd0, cpl_valid}, 32'd0);
    send(2, 16'h7777);
    cpl_ready = 1;
    pulse_done(32'h0000_0004);
    step();
    check(cpl_rid === 16'h7777 && cpl_vec === 32'h4, "R10 recapture rid",
          {cpl_rid, cpl_vec[15:0]}, {16'h7777, 16'h0004});
    repeat (3) step();
    finish_run();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finish_run();
    end
  end
endmodule